// File: doc/BRIEF.md
# Track-signal bit slicer

This block recovers the bit stream carried by a squared model-railway control signal. Every rising edge of the line restarts a microsecond timer. At a fixed sample point after that edge the block looks at the line again. A line that is already low gives a 1, because its half-period was short. A line that is still high gives a 0.

The recovered bit appears on a data output. A bit strobe follows one clock later and clears itself at a later fixed point. Downstream logic can therefore register the data on the strobe's rising edge and find it stable.

The line input is asynchronous. It passes through a two-flop synchronizer before any edge detection or sampling. Everything runs in the one system clock domain, and the strobe is a registered output that clocks nothing inside the block. Framing, preamble search, addressing and error checks are the job of later stages.

Top module: `dcc_bit_slicer`

## Requirements
- R1: Only a rising edge of the synchronized line starts a bit period. Count as edge 1 the first clock edge at which the input is high after being low. The data output then updates after clock edge SAMPLE_US*CLK_PER_US+3.
- R2: At the sample point the data output takes the inverse of the synchronized line. A low line gives 1 and a high line gives 0.
- R3: The strobe rises one clock after the data update, after edge SAMPLE_US*CLK_PER_US+4. The data output does not change while the strobe is high.
- R4: The strobe returns low after edge RELEASE_US*CLK_PER_US+3, counted from the same edge 1.
- R5: A new rising edge restarts the timer and clears a pending or active strobe after its own edge 3, without emitting a second strobe. A period cut short before the sample point leaves the data unchanged and gives no strobe.
- R6: An active-low asynchronous reset clears the data output and the strobe. A line that is held high through reset release starts no bit period, and the block stays idle until the line first goes low and then rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dcc_i | input | 1 | Squared track signal, asynchronous |
| bit_o | output | 1 | Recovered bit value |
| bit_clk_o | output | 1 | Bit strobe, data is stable while it is high |

## Verification
The assertions assume two things about the line. First, a synchronized rising edge lasts one cycle, because the line stays high for at least two clocks. Second, SAMPLE_US is smaller than RELEASE_US, so the sample and release events never coincide. The stimulus keeps within this by holding each half-period for tens of microseconds. Half-periods are chosen well away from the sample point, so the synchronizer latency never makes the expected bit ambiguous. The short-pulse and restart cases use edges that land well before and well after the sample point.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef struct packed {
    logic sample;  // sample point reached this cycle
    logic rel;     // strobe release point reached this cycle
  } tick_t;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/dcc_in_sync.sv
module dcc_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // reset to 1 so a line held high through reset gives no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_o = sync_q[STAGES-1];
  assign rise_o = line_o & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R1

endmodule

// File: rtl/dcc_us_timer.sv
module dcc_us_timer
  import dcc_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 125,
  parameter int unsigned SAMPLE_US  = 80,
  parameter int unsigned RELEASE_US = 100
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  output tick_t tick_o
);

  localparam int unsigned PRE_W = cnt_width(CLK_PER_US - 1);
  localparam int unsigned US_W  = cnt_width(RELEASE_US);
  localparam logic [PRE_W-1:0] PRE_MAX  = PRE_W'(CLK_PER_US - 1);
  localparam logic [US_W-1:0]  US_SAMP  = US_W'(SAMPLE_US - 1);
  localparam logic [US_W-1:0]  US_REL   = US_W'(RELEASE_US - 1);

  logic             active_q;
  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;
  logic             us_tick;

  assign us_tick = active_q & (pre_q == PRE_MAX) & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pre_q    <= '0;
      us_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      pre_q    <= '0;
      us_q     <= '0;
    end else if (active_q) begin
      if (pre_q == PRE_MAX) begin
        pre_q <= '0;
        us_q  <= us_q + 1'b1;
        if (us_q == US_REL) active_q <= 1'b0;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign tick_o.sample = us_tick & (us_q == US_SAMP);
  assign tick_o.rel    = us_tick & (us_q == US_REL);

  AST_TICKS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tick_o.sample, tick_o.rel})); // R4

endmodule

// File: rtl/dcc_bit_out.sv
module dcc_bit_out
  import dcc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  tick_t tick_i,
  input  logic  line_i,
  output logic  bit_o,
  output logic  bit_clk_o
);

  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o     <= 1'b0;
      pend_q    <= 1'b0;
      bit_clk_o <= 1'b0;
    end else begin
      if (tick_i.sample) bit_o <= ~line_i;  // long high half = 0
      pend_q <= tick_i.sample & ~start_i;
      if (start_i || tick_i.rel) bit_clk_o <= 1'b0;
      else if (pend_q)           bit_clk_o <= 1'b1;
    end
  end

  AST_STROBE_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bit_clk_o) |-> $past(tick_i.sample, 2)); // R3

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_clk_o |=> $stable(bit_o)); // R3

endmodule

// File: rtl/dcc_bit_slicer.sv
module dcc_bit_slicer
  import dcc_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 125,
  parameter int unsigned SAMPLE_US  = 80,
  parameter int unsigned RELEASE_US = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dcc_i,
  output logic bit_o,
  output logic bit_clk_o
);

  logic  line_s;
  logic  rise;
  tick_t tick;

  dcc_in_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (dcc_i),
    .line_o (line_s),
    .rise_o (rise)
  );

  dcc_us_timer #(
    .CLK_PER_US (CLK_PER_US),
    .SAMPLE_US  (SAMPLE_US),
    .RELEASE_US (RELEASE_US)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rise),
    .tick_o  (tick)
  );

  dcc_bit_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (rise),
    .tick_i    (tick),
    .line_i    (line_s),
    .bit_o     (bit_o),
    .bit_clk_o (bit_clk_o)
  );

  AST_EDGE_DROPS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !bit_clk_o); // R5

  AST_RELEASE_DROPS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick.rel |=> !bit_clk_o); // R4

endmodule

// File: tb/dcc_bit_slicer_tb.sv
module dcc_bit_slicer_tb;

  localparam int N  = 4;
  localparam int S  = 80;
  localparam int R  = 100;
  localparam int SN = S * N;
  localparam int RN = R * N;
  localparam int NV = 6;

  // {high_us, low_us, expected bit}
  localparam int VEC [NV][3] = '{
    '{58, 58, 1}, '{100, 100, 0}, '{58, 58, 1},
    '{116, 116, 0}, '{61, 61, 1}, '{100, 58, 0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dcc_i = 1'b0;
  logic bit_o, bit_clk_o;
  logic prev_bit = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;

  always #4 clk_i = ~clk_i;

  dcc_bit_slicer #(.CLK_PER_US(N), .SAMPLE_US(S), .RELEASE_US(R)) u_dut (
    .clk_i, .rst_ni, .dcc_i, .bit_o, .bit_clk_o
  );

  task automatic check(input logic act, input logic exp, input string msg);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", msg, act, exp);
    end
  endtask

  task automatic send_bit(input int hi, input int lo, input logic expb, input logic clr_chk);
    int total;
    total = (hi + lo) * N;
    @(negedge clk_i);
    dcc_i = 1'b1;
    for (int t = 1; t <= total; t++) begin
      @(negedge clk_i);
      if (t == hi * N) dcc_i = 1'b0;
      if (clr_chk && t == 2) check(bit_clk_o, 1'b1, "R5 strobe still high before restart");
      if (clr_chk && t == 3) check(bit_clk_o, 1'b0, "R5 restart clears strobe");
      if (t == SN + 2) begin
        check(bit_o, prev_bit, "R1 data not yet updated");
        check(bit_clk_o, 1'b0, "R3 strobe low before data");
      end
      if (t == SN + 3) begin
        check(bit_o, expb, "R1 R2 sampled bit");
        check(bit_clk_o, 1'b0, "R3 strobe follows data");
      end
      if (t == SN + 4) check(bit_clk_o, 1'b1, "R3 strobe rises");
      if (t == RN + 2) check(bit_clk_o, 1'b1, "R4 strobe held");
      if (t == RN + 3) check(bit_clk_o, 1'b0, "R4 strobe released");
    end
    if (total >= SN + 3) prev_bit = expb;
    else begin
      check(bit_clk_o, 1'b0, "R5 short period gives no strobe");
      check(bit_o, prev_bit, "R5 short period keeps data");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    check(bit_o, 1'b0, "R6 reset data");
    check(bit_clk_o, 1'b0, "R6 reset strobe");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    for (int i = 0; i < NV; i++)
      send_bit(VEC[i][0], VEC[i][1], VEC[i][2] != 0, 1'b0);

    // short glitch before the sample point, then a normal bit
    send_bit(20, 20, 1'b0, 1'b0);
    send_bit(58, 58, 1'b1, 1'b0);

    // edge after the sample point but before release
    send_bit(90, 5, 1'b0, 1'b0);
    send_bit(58, 58, 1'b1, 1'b1);

    // reset while strobe is high, line held high through release
    @(negedge clk_i);
    dcc_i = 1'b1;
    repeat (SN + 10) @(negedge clk_i);
    check(bit_clk_o, 1'b1, "R3 strobe high before reset");
    rst_ni = 1'b0;
    #1;
    check(bit_o, 1'b0, "R6 async reset data");
    check(bit_clk_o, 1'b0, "R6 async reset strobe");
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev_bit = 1'b0;
    repeat (SN + 4) @(negedge clk_i);
    check(bit_clk_o, 1'b0, "R6 no strobe with line held high");
    repeat (RN) @(negedge clk_i);
    check(bit_o, 1'b0, "R6 idle data");
    check(bit_clk_o, 1'b0, "R6 idle strobe");
    dcc_i = 1'b0;
    repeat (20) @(negedge clk_i);
    send_bit(58, 58, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule